// File: doc/BRIEF.md
# Message Event Interrupt and Failsafe Timer

This block sits beside the protocol engine of a serial-bus remote terminal and turns the engine's one-cycle event strobes into the signals the host and the line drivers watch. It makes two fixed-width active-low interrupt pulses: a selectable one for the end of data-transfer activity and an unmaskable one for the end of mode-command activity. It also drives an active-low pulse for each accepted command word and a level message-error flag that holds until the next command arrives.

The block also bounds how long the transmitters may stay on. A start event opens a transmit window that closes on the finish event. If no finish arrives within a limit that depends on the protocol variant, the window closes by itself. Transmission is then inhibited until a new valid command word is seen. A superseding-reset input clears all pulse, error, window and inhibit state in one cycle. The interrupt select is an input owned by the control register, so that input does not change it.

Every input is a level sampled on the rising clock edge. Event inputs are meant to be high for one cycle each. There is no data stream and no handshake.

Top module: `msg_event_irq`

## Requirements
- R1: `xfer_sel` picks the events that raise `xfer_irq_n`. Bit 0 enables `rx_done` and bit 1 enables `tx_done`, so 2'b00 disables the pulse and 2'b11 enables both. An event that is not enabled leaves `xfer_irq_n` high.
- R2: An enabled transfer event drives `xfer_irq_n` low from the cycle after it for exactly PULSE_CYC cycles (default 3).
- R3: `mc_done` drives `mode_irq_n` low from the next cycle for PULSE_CYC cycles, whatever the value of `xfer_sel`.
- R4: No interrupt pulse starts for an event that arrives while the error flag is set, or in the same cycle as `msg_err`.
- R5: `err_flag_n` goes low the cycle after `msg_err` and stays low.
- R6: `err_flag_n` returns high the cycle after `cmd_valid`, unless `msg_err` is high in that same cycle (setting wins).
- R7: Each `cmd_valid` drives `cmd_strobe_n` low from the next cycle for PULSE_CYC cycles.
- R8: `xmit_window` rises the cycle after `tx_start` and falls the cycle after `tx_finish`. A start while the window is open has no effect.
- R9: If no `tx_finish` arrives, `xmit_window` stays high for exactly FS_CYC_A cycles when `proto_a_sel` was 1 at the start, or FS_CYC_B cycles when it was 0. It then drops, and `tx_inhibit` rises in the same cycle.
- R10: While `tx_inhibit` is high, `tx_start` is ignored. `tx_inhibit` clears the cycle after `cmd_valid`, and a `tx_start` given together with that `cmd_valid` opens a window.
- R11: After reset, and the cycle after `supersede`, all active-low outputs are high and `xmit_window` and `tx_inhibit` are low. `supersede` outranks every other input, and the interrupt select still applies afterwards.
- R12: A new trigger that arrives during a pulse restarts that pulse's full width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supersede | input | 1 | Synchronous clear of all event state |
| cmd_valid | input | 1 | Valid command word received (strobe) |
| rx_done | input | 1 | End of receive memory activity (strobe) |
| tx_done | input | 1 | End of transmit memory activity (strobe) |
| mc_done | input | 1 | End of mode-command memory activity (strobe) |
| msg_err | input | 1 | Message error detected (strobe) |
| tx_start | input | 1 | Transmitter about to start (strobe) |
| tx_finish | input | 1 | Transmission complete (strobe) |
| xfer_sel | input | 2 | Transfer interrupt select, bit0 receive, bit1 transmit |
| proto_a_sel | input | 1 | 1 selects the variant-A failsafe limit, 0 variant B |
| xfer_irq_n | output | 1 | End-of-transfer interrupt pulse, active low |
| mode_irq_n | output | 1 | End-of-mode-command interrupt pulse, active low |
| err_flag_n | output | 1 | Message error flag, active low |
| cmd_strobe_n | output | 1 | Command accepted pulse, active low |
| xmit_window | output | 1 | Transmit window open |
| tx_inhibit | output | 1 | Transmitters latched off after a failsafe expiry |

## Verification
Every output is registered once after its cause, so a pulse, the error flag and the window all change on the edge that samples the stimulus and are visible one cycle later. A pulse then lasts PULSE_CYC cycles. A failsafe expiry comes FS_CYC_A or FS_CYC_B cycles after the start. The bench drives inputs at the falling edge and advances a per-cycle expected model on each rising edge. It compares every output at the next falling edge, so each result is checked in the exact cycle it is due, and a late or early change shows up as a mismatch.

// File: rtl/mei_pkg.sv
package mei_pkg;
  typedef enum logic [1:0] {
    XSEL_OFF  = 2'b00,
    XSEL_RX   = 2'b01,
    XSEL_TX   = 2'b10,
    XSEL_BOTH = 2'b11
  } xfer_sel_e;

  localparam int unsigned N_PULSE   = 3;
  localparam int unsigned PIDX_XFER = 0;
  localparam int unsigned PIDX_MODE = 1;
  localparam int unsigned PIDX_CMD  = 2;
endpackage

// File: rtl/mei_pulse_gen.sv
module mei_pulse_gen #(
  parameter int unsigned PW = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic trig,
  output logic pulse_n
);
  localparam int unsigned CW = $clog2(PW + 1);
  localparam logic [CW-1:0] LOAD = CW'(PW);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (clr)            cnt_q <= '0;
    else if (trig)           cnt_q <= LOAD;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign pulse_n = (cnt_q == '0);
endmodule

// File: rtl/mei_failsafe_timer.sv
module mei_failsafe_timer #(
  parameter int unsigned FS_A = 600,
  parameter int unsigned FS_B = 800
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic start,
  input  logic finish,
  input  logic cmd_valid,
  input  logic variant_a,
  output logic window,
  output logic inhibit
);
  localparam int unsigned FS_MAX = (FS_A > FS_B) ? FS_A : FS_B;
  localparam int unsigned CW     = $clog2(FS_MAX + 1);
  localparam logic [CW-1:0] LAST_A = CW'(FS_A - 1);
  localparam logic [CW-1:0] LAST_B = CW'(FS_B - 1);

  logic [CW-1:0] cnt_q;
  logic          act_q;
  logic          inh_q;
  logic          lim_a_q;
  logic          expire;
  logic          may_start;

  assign expire    = act_q && !finish && (cnt_q == (lim_a_q ? LAST_A : LAST_B));
  assign may_start = !act_q && start && (!inh_q || cmd_valid);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      act_q   <= 1'b0;
      inh_q   <= 1'b0;
      lim_a_q <= 1'b0;
    end else if (clr) begin
      cnt_q   <= '0;
      act_q   <= 1'b0;
      inh_q   <= 1'b0;
      lim_a_q <= 1'b0;
    end else begin
      if (act_q) begin
        if (finish || expire) act_q <= 1'b0;
        else                  cnt_q <= cnt_q + 1'b1;
      end else if (may_start) begin
        act_q   <= 1'b1;
        cnt_q   <= '0;
        lim_a_q <= variant_a;
      end
      if (expire)         inh_q <= 1'b1;
      else if (cmd_valid) inh_q <= 1'b0;
    end
  end

  assign window  = act_q;
  assign inhibit = inh_q;
endmodule

// File: rtl/msg_event_irq.sv
module msg_event_irq
  import mei_pkg::*;
#(
  parameter int unsigned PULSE_CYC = 3,
  parameter int unsigned FS_CYC_A  = 600,
  parameter int unsigned FS_CYC_B  = 800
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       supersede,
  input  logic       cmd_valid,
  input  logic       rx_done,
  input  logic       tx_done,
  input  logic       mc_done,
  input  logic       msg_err,
  input  logic       tx_start,
  input  logic       tx_finish,
  input  logic [1:0] xfer_sel,
  input  logic       proto_a_sel,
  output logic       xfer_irq_n,
  output logic       mode_irq_n,
  output logic       err_flag_n,
  output logic       cmd_strobe_n,
  output logic       xmit_window,
  output logic       tx_inhibit
);
  xfer_sel_e          sel;
  logic               err_q;
  logic               blocked;
  logic [N_PULSE-1:0] trig;
  logic [N_PULSE-1:0] pls_n;

  assign sel     = xfer_sel_e'(xfer_sel);
  assign blocked = err_q || msg_err;

  always_comb begin
    trig = '0;
    trig[PIDX_XFER] = !blocked &&
                      ((rx_done && (sel == XSEL_RX || sel == XSEL_BOTH)) ||
                       (tx_done && (sel == XSEL_TX || sel == XSEL_BOTH)));
    trig[PIDX_MODE] = !blocked && mc_done;
    trig[PIDX_CMD]  = cmd_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         err_q <= 1'b0;
    else if (supersede) err_q <= 1'b0;
    else if (msg_err)   err_q <= 1'b1;
    else if (cmd_valid) err_q <= 1'b0;
  end

  for (genvar g = 0; g < N_PULSE; g++) begin : g_pulse
    mei_pulse_gen #(.PW(PULSE_CYC)) u_pg (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (supersede),
      .trig    (trig[g]),
      .pulse_n (pls_n[g])
    );
  end

  mei_failsafe_timer #(.FS_A(FS_CYC_A), .FS_B(FS_CYC_B)) u_fs (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (supersede),
    .start     (tx_start),
    .finish    (tx_finish),
    .cmd_valid (cmd_valid),
    .variant_a (proto_a_sel),
    .window    (xmit_window),
    .inhibit   (tx_inhibit)
  );

  assign xfer_irq_n   = pls_n[PIDX_XFER];
  assign mode_irq_n   = pls_n[PIDX_MODE];
  assign cmd_strobe_n = pls_n[PIDX_CMD];
  assign err_flag_n   = !err_q;
endmodule

// File: rtl/msg_event_irq_chk.sv
module msg_event_irq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       supersede,
  input logic       cmd_valid,
  input logic       mc_done,
  input logic       msg_err,
  input logic       tx_finish,
  input logic [1:0] xfer_sel,
  input logic       xfer_irq_n,
  input logic       mode_irq_n,
  input logic       err_flag_n,
  input logic       cmd_strobe_n,
  input logic       xmit_window,
  input logic       tx_inhibit
);
  a_r1_sel_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_sel == 2'b00 && xfer_irq_n && !supersede) |=> xfer_irq_n);

  a_r3_mode_irq_fires: assert property (@(posedge clk) disable iff (!rst_n)
    (mc_done && err_flag_n && !msg_err && !supersede) |=> !mode_irq_n);

  a_r4_no_xfer_on_err: assert property (@(posedge clk) disable iff (!rst_n)
    (!err_flag_n && xfer_irq_n && !supersede) |=> xfer_irq_n);

  a_r4_no_mode_on_err: assert property (@(posedge clk) disable iff (!rst_n)
    (!err_flag_n && mode_irq_n && !supersede) |=> mode_irq_n);

  a_r5_err_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_err && !supersede) |=> !err_flag_n);

  a_r6_err_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !msg_err && !supersede) |=> err_flag_n);

  a_r7_cmd_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !supersede) |=> !cmd_strobe_n);

  a_r8_finish_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (xmit_window && tx_finish && !supersede) |=> !xmit_window);

  a_r10_inhibit_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_inhibit && !cmd_valid && !supersede) |=> (tx_inhibit && !xmit_window));

  a_r11_supersede_clears: assert property (@(posedge clk) disable iff (!rst_n)
    supersede |=> (xfer_irq_n && mode_irq_n && err_flag_n && cmd_strobe_n &&
                   !xmit_window && !tx_inhibit));
endmodule

bind msg_event_irq msg_event_irq_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .supersede    (supersede),
  .cmd_valid    (cmd_valid),
  .mc_done      (mc_done),
  .msg_err      (msg_err),
  .tx_finish    (tx_finish),
  .xfer_sel     (xfer_sel),
  .xfer_irq_n   (xfer_irq_n),
  .mode_irq_n   (mode_irq_n),
  .err_flag_n   (err_flag_n),
  .cmd_strobe_n (cmd_strobe_n),
  .xmit_window  (xmit_window),
  .tx_inhibit   (tx_inhibit)
);

// File: tb/msg_event_irq_tb_top.sv
module msg_event_irq_tb_top;
  localparam int PW   = 3;
  localparam int LIMA = 600;
  localparam int LIMB = 800;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supersede = 0, cmd_valid = 0, rx_done = 0, tx_done = 0, mc_done = 0;
  logic msg_err = 0, tx_start = 0, tx_finish = 0, proto_a_sel = 0;
  logic [1:0] xfer_sel = 2'b00;
  logic xfer_irq_n, mode_irq_n, err_flag_n, cmd_strobe_n, xmit_window, tx_inhibit;

  int checks = 0;
  int failures = 0;

  // expected-value model state
  int  m_xfer = 0, m_mode = 0, m_cmd = 0, m_cnt = 0, m_lim = 0;
  bit  m_err = 0, m_act = 0, m_inh = 0;

  always #2 clk = ~clk;

  msg_event_irq dut_i (
    .clk(clk), .rst_n(rst_n), .supersede(supersede), .cmd_valid(cmd_valid),
    .rx_done(rx_done), .tx_done(tx_done), .mc_done(mc_done), .msg_err(msg_err),
    .tx_start(tx_start), .tx_finish(tx_finish), .xfer_sel(xfer_sel),
    .proto_a_sel(proto_a_sel), .xfer_irq_n(xfer_irq_n), .mode_irq_n(mode_irq_n),
    .err_flag_n(err_flag_n), .cmd_strobe_n(cmd_strobe_n),
    .xmit_window(xmit_window), .tx_inhibit(tx_inhibit)
  );

  function automatic int next_pulse(int cur, bit trg);
    if (trg) return PW;
    return (cur > 0) ? cur - 1 : 0;
  endfunction

  task automatic model_step();
    bit blk, tx, tm, expd;
    if (supersede) begin
      m_xfer = 0; m_mode = 0; m_cmd = 0; m_err = 0; m_act = 0; m_inh = 0; m_cnt = 0;
      return;
    end
    blk = m_err | msg_err;
    tx  = !blk && ((rx_done && xfer_sel[0]) || (tx_done && xfer_sel[1]));
    tm  = !blk && mc_done;
    m_xfer = next_pulse(m_xfer, tx);
    m_mode = next_pulse(m_mode, tm);
    m_cmd  = next_pulse(m_cmd, cmd_valid);
    if (msg_err) m_err = 1; else if (cmd_valid) m_err = 0;
    expd = 0;
    if (m_act) begin
      if (tx_finish) m_act = 0;
      else if (m_cnt == m_lim - 1) begin m_act = 0; expd = 1; end
      else m_cnt++;
    end else if (tx_start && (!m_inh || cmd_valid)) begin
      m_act = 1; m_cnt = 0; m_lim = proto_a_sel ? LIMA : LIMB;
    end
    if (expd) m_inh = 1; else if (cmd_valid) m_inh = 0;
  endtask

  task automatic chk(string req, string nm, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s act=%0b exp=%0b t=%0t", req, nm, act, exp, $time);
    end
  endtask

  task automatic compare(string req);
    chk(req, "xfer_irq_n",   xfer_irq_n,   m_xfer == 0);
    chk(req, "mode_irq_n",   mode_irq_n,   m_mode == 0);
    chk(req, "err_flag_n",   err_flag_n,   !m_err);
    chk(req, "cmd_strobe_n", cmd_strobe_n, m_cmd == 0);
    chk(req, "xmit_window",  xmit_window,  m_act);
    chk(req, "tx_inhibit",   tx_inhibit,   m_inh);
  endtask

  task automatic clear_in();
    supersede = 0; cmd_valid = 0; rx_done = 0; tx_done = 0; mc_done = 0;
    msg_err = 0; tx_start = 0; tx_finish = 0;
  endtask

  task automatic tick(string req);
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare(req);
    clear_in();
  endtask

  task automatic idle(int n, string req);
    for (int i = 0; i < n; i++) tick(req);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog act=running exp=finished");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare("R11");
    rst_n = 1'b1;
    idle(2, "R11");

    // R1 / R2: every select value against both events
    for (int s = 0; s < 4; s++) begin
      xfer_sel = 2'(s);
      rx_done = 1; tick("R1"); idle(5, "R2");
      tx_done = 1; tick("R1"); idle(5, "R2");
    end

    // R12: retrigger during a pulse restarts the width
    xfer_sel = 2'b11;
    rx_done = 1; tick("R12");
    tick("R12");
    tx_done = 1; tick("R12");
    idle(5, "R12");

    // R3: mode pulse with transfer select off
    xfer_sel = 2'b00;
    mc_done = 1; tick("R3"); idle(4, "R3");

    // R4 / R5: error blocks both pulses
    xfer_sel = 2'b11;
    msg_err = 1; mc_done = 1; rx_done = 1; tick("R4");
    idle(2, "R5");
    mc_done = 1; tx_done = 1; tick("R4"); idle(4, "R4");

    // R6 / R7: command clears error, strobes; same-cycle set wins
    cmd_valid = 1; tick("R6"); idle(4, "R7");
    cmd_valid = 1; msg_err = 1; tick("R6"); idle(2, "R6");
    cmd_valid = 1; rx_done = 1; tick("R4"); idle(4, "R4");
    mc_done = 1; tick("R3"); idle(4, "R3");

    // R8: window open and close, restart ignored while open
    tx_start = 1; tick("R8"); idle(3, "R8");
    tx_start = 1; tick("R8"); idle(3, "R8");
    tx_finish = 1; tick("R8"); idle(2, "R8");

    // R9 / R10: variant A expiry, inhibit, clearing
    proto_a_sel = 1;
    tx_start = 1; tick("R9");
    proto_a_sel = 0;
    idle(LIMA + 3, "R9");
    tx_start = 1; tick("R10"); idle(3, "R10");
    cmd_valid = 1; tick("R10"); idle(2, "R10");
    tx_start = 1; tick("R9"); idle(LIMB + 3, "R9");
    cmd_valid = 1; tx_start = 1; tick("R10"); idle(3, "R10");
    tx_finish = 1; tick("R8"); idle(2, "R8");

    // R11: supersede mid-activity, select still honoured after
    xfer_sel = 2'b01;
    tx_start = 1; cmd_valid = 1; tick("R11");
    msg_err = 1; tick("R11");
    supersede = 1; rx_done = 1; msg_err = 1; tick("R11");
    idle(2, "R11");
    rx_done = 1; tick("R11"); idle(4, "R11");
    tx_done = 1; tick("R11"); idle(4, "R11");

    // random mix
    for (int i = 0; i < 6000; i++) begin
      int r;
      r = $urandom % 1000;
      cmd_valid   = (r < 40);
      rx_done     = ($urandom % 100) < 6;
      tx_done     = ($urandom % 100) < 6;
      mc_done     = ($urandom % 100) < 4;
      msg_err     = ($urandom % 100) < 2;
      tx_start    = ($urandom % 100) < 3;
      tx_finish   = ($urandom % 1000) < 2;
      supersede   = ($urandom % 1000) < 2;
      if (($urandom % 200) == 0) xfer_sel = 2'($urandom % 4);
      proto_a_sel = $urandom % 2;
      tick("R2/R4/R9");
    end
    idle(4, "R2");

    summary();
    $finish;
  end
endmodule